// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This block runs the SM3 message-expansion recurrence over a range of element groups. Each group holds sixteen 32-bit message words: eight from a first source operand (W0..W7) and eight from a second (W8..W15). From these it produces the next eight expanded words, W16..W23. Words travel in little-endian byte order on the ports. The unit reverses the bytes of each word on entry and again on exit.

A command gives a first group index and an end group index, both counted in groups of eight words. The unit then takes one group per accepted transfer, from the first index up to but not including the end index. It returns one registered result per group, tagged with the group's index. After the last group it pulses a completion flag and its resume index goes back to zero. Later words of a group depend on earlier words of the same group, so the eight outputs form one chained recurrence and not eight separate lanes.

The caller must guarantee the following. The element width is 32 bits. The destination group does not overlap the second source group. Register access, masking and decode stay outside the block.

Top module: `sm3me_unit`

## Requirements
- R1: Input word k (k = 0..7) of each source operand sits at bits [32k+31:32k]. Its four bytes are reversed before use. Each result word is byte-reversed before it is driven out.
- R2: For j = 0..7, W[j+16] = P1(W[j] ^ W[j+7] ^ rotl(W[j+13],15)) ^ rotl(W[j+3],7) ^ W[j+10], where P1(x) = x ^ rotl(x,15) ^ rotl(x,23). For the standard padded message "abc", the first eight expanded words are 9092e200, 00000000, 000c0606, 719c70ed, 00000000, 8001801f, 939f7da9, 00000000.
- R3: When j >= 3, the W[j+13] term is the word computed earlier in the same group. It is never the stale input.
- R4: Result word k, at bits [32k+31:32k], carries W[16+k].
- R5: A group accepted on one clock edge (grp_valid and grp_ready both high) gives res_valid high for exactly the following cycle. That result carries the group's data and index. Without an accepted group, res_valid stays low.
- R6: grp_ready is high only while a run is active. Groups take the indices first, first+1, ... end-1 in order, one per accepted transfer. pos_idx shows the index of the next group.
- R7: done is high for exactly one cycle. That is the cycle after the edge that accepts the last group, which is the same cycle as that group's result. pos_idx then reads 0 and cmd_ready reads 1.
- R8: A command with first >= end runs no group. done pulses in the cycle after the command is accepted, and res_valid stays low.
- R9: cmd_ready is high only while idle. A command presented during a run has no effect on the indices or the completion of that run.
- R10: During and after reset, cmd_ready = 1, grp_ready = 0, res_valid = 0, done = 0 and pos_idx = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Idle, command can be taken |
| cmd_first | input | IDX_W | First group index |
| cmd_end | input | IDX_W | End group index (exclusive) |
| grp_valid | input | 1 | Group data present |
| grp_ready | output | 1 | Run active, group can be taken |
| grp_src1 | input | 256 | Source words giving W0..W7 |
| grp_src2 | input | 256 | Source words giving W8..W15 |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | 256 | Expanded words W16..W23 |
| res_index | output | IDX_W | Group index of the result |
| pos_idx | output | IDX_W | Next group index, 0 when idle |
| done | output | 1 | Run finished pulse |

## Verification
Each accepted group has exactly one register between its inputs and its result. Its data and index are therefore due at the first sample point after the accepting edge, and the done pulse of the last group is due in that same cycle. Command effects (grp_ready, pos_idx, the empty-range done) are also due one edge after acceptance. The bench drives inputs on the falling edge, so it checks each result at the very next falling edge and checks one more falling edge later that done has dropped. Results are compared against a model of the recurrence computed inside the bench, and the "abc" vector is also compared against the published constants.

// File: rtl/sm3me_pkg.sv
package sm3me_pkg;

  localparam int WORD_W    = 32;
  localparam int GRP_WORDS = 8;
  localparam int GRP_W     = WORD_W * GRP_WORDS;
  localparam int SCHED_LEN = 3 * GRP_WORDS;

  // rotation amounts of the expansion step
  localparam int ROT_MIX  = 15;
  localparam int ROT_TAP  = 7;
  localparam int ROT_P1_A = 15;
  localparam int ROT_P1_B = 23;

  function automatic logic [WORD_W-1:0] rotl32(input logic [WORD_W-1:0] x,
                                               input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] perm1(input logic [WORD_W-1:0] x);
    return x ^ rotl32(x, ROT_P1_A) ^ rotl32(x, ROT_P1_B);
  endfunction

endpackage

// File: rtl/sm3me_bswap.sv
module sm3me_bswap #(
  parameter int WORDS = 8
) (
  input  logic [WORDS*32-1:0] din,
  output logic [WORDS*32-1:0] dout
);

  localparam int BYTES = 4;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign dout[k*32 + b*8 +: 8] = din[k*32 + (BYTES-1-b)*8 +: 8];
    end
  end

endmodule

// File: rtl/sm3me_expand.sv
module sm3me_expand
  import sm3me_pkg::*;
(
  input  logic [GRP_W-1:0] lo_words,
  input  logic [GRP_W-1:0] hi_words,
  output logic [GRP_W-1:0] next_words
);

  logic [WORD_W-1:0] sched [SCHED_LEN];

  // Evaluated in index order so that each new word sees the ones before it.
  always_comb begin
    for (int i = 0; i < GRP_WORDS; i++) begin
      sched[i]             = lo_words[i*WORD_W +: WORD_W];
      sched[i + GRP_WORDS] = hi_words[i*WORD_W +: WORD_W];
    end
    for (int i = 2*GRP_WORDS; i < SCHED_LEN; i++) begin
      sched[i] = perm1(sched[i-16] ^ sched[i-9] ^ rotl32(sched[i-3], ROT_MIX))
               ^ rotl32(sched[i-13], ROT_TAP)
               ^ sched[i-6];
    end
    for (int i = 0; i < GRP_WORDS; i++) begin
      next_words[i*WORD_W +: WORD_W] = sched[i + 2*GRP_WORDS];
    end
  end

endmodule

// File: rtl/sm3me_ctrl.sv
module sm3me_ctrl #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [IDX_W-1:0] cmd_first,
  input  logic [IDX_W-1:0] cmd_end,
  input  logic             grp_valid,
  output logic             cmd_ready,
  output logic             grp_ready,
  output logic             grp_take,
  output logic [IDX_W-1:0] take_idx,
  output logic [IDX_W-1:0] pos_idx,
  output logic             done
);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] end_q, end_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_inc;
  logic             cmd_take;

  assign cmd_ready = !busy_q;
  assign grp_ready = busy_q;
  assign cmd_take  = cmd_valid && !busy_q;
  assign grp_take  = grp_valid && busy_q;
  assign idx_inc   = idx_q + 1'b1;
  assign take_idx  = idx_q;
  assign pos_idx   = idx_q;
  assign done      = done_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    end_d  = end_q;
    done_d = 1'b0;
    if (cmd_take) begin
      if (cmd_first < cmd_end) begin
        busy_d = 1'b1;
        idx_d  = cmd_first;
        end_d  = cmd_end;
      end else begin
        done_d = 1'b1;
      end
    end else if (grp_take) begin
      if (idx_inc == end_q) begin
        busy_d = 1'b0;
        idx_d  = '0;
        done_d = 1'b1;
      end else begin
        idx_d  = idx_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      end_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      end_q  <= end_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/sm3me_unit.sv
module sm3me_unit
  import sm3me_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [IDX_W-1:0] cmd_first,
  input  logic [IDX_W-1:0] cmd_end,
  input  logic             grp_valid,
  output logic             grp_ready,
  input  logic [255:0]     grp_src1,
  input  logic [255:0]     grp_src2,
  output logic             res_valid,
  output logic [255:0]     res_data,
  output logic [IDX_W-1:0] res_index,
  output logic [IDX_W-1:0] pos_idx,
  output logic             done
);

  logic [GRP_W-1:0] lo_be, hi_be, nxt_be, nxt_le;
  logic             grp_take;
  logic [IDX_W-1:0] take_idx;
  logic             rv_q, rv_d;
  logic [IDX_W-1:0] ri_q, ri_d;
  logic [GRP_W-1:0] rd_q;

  sm3me_bswap #(.WORDS(GRP_WORDS)) u_in_lo (.din(grp_src1), .dout(lo_be));
  sm3me_bswap #(.WORDS(GRP_WORDS)) u_in_hi (.din(grp_src2), .dout(hi_be));

  sm3me_expand u_expand (
    .lo_words  (lo_be),
    .hi_words  (hi_be),
    .next_words(nxt_be)
  );

  sm3me_bswap #(.WORDS(GRP_WORDS)) u_out (.din(nxt_be), .dout(nxt_le));

  sm3me_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_first(cmd_first),
    .cmd_end  (cmd_end),
    .grp_valid(grp_valid),
    .cmd_ready(cmd_ready),
    .grp_ready(grp_ready),
    .grp_take (grp_take),
    .take_idx (take_idx),
    .pos_idx  (pos_idx),
    .done     (done)
  );

  always_comb begin
    rv_d = grp_take;
    ri_d = grp_take ? take_idx : ri_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      ri_q <= '0;
    end else begin
      rv_q <= rv_d;
      ri_q <= ri_d;
    end
  end

  // datapath register, enable only, no reset
  always_ff @(posedge clk) begin
    if (grp_take) begin
      rd_q <= nxt_le;
    end
  end

  assign res_valid = rv_q;
  assign res_index = ri_q;
  assign res_data  = rd_q;

endmodule

// File: rtl/sm3me_unit_chk.sv
module sm3me_unit_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             grp_valid,
  input logic             grp_ready,
  input logic             res_valid,
  input logic [IDX_W-1:0] res_index,
  input logic [IDX_W-1:0] pos_idx,
  input logic             done
);

  // R5
  res_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_ready) |=> res_valid);

  // R5
  no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grp_valid && grp_ready) |=> !res_valid);

  // R6
  res_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && grp_ready) |=> (res_index == $past(pos_idx)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  idle_pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (pos_idx == '0));

  // R9
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready != grp_ready);

endmodule

bind sm3me_unit sm3me_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_ready(cmd_ready),
  .grp_valid(grp_valid),
  .grp_ready(grp_ready),
  .res_valid(res_valid),
  .res_index(res_index),
  .pos_idx  (pos_idx),
  .done     (done)
);

// File: tb/sm3me_unit_tb.sv
`timescale 1ns/1ps
module sm3me_unit_tb;

  localparam int IDX_W = 8;
  localparam int NVEC  = 5;

  localparam logic [255:0] TV_S1 [NVEC] = '{
    256'h00000000_00000000_00000000_00000000_00000000_00000000_00000000_80636261,
    256'h0,
    {256{1'b1}},
    256'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0_00112233_44556677_8899aabb_ccddeeff,
    256'h0
  };
  localparam logic [255:0] TV_S2 [NVEC] = '{
    256'h18000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000,
    256'h0,
    {256{1'b1}},
    256'hdeadbeef_01234567_89abcdef_fedcba98_76543210_cafef00d_13579bdf_2468ace0,
    256'h00000000_00000000_01000000_00000000_00000000_00000000_00000000_00000000
  };
  localparam logic [255:0] ABC_EXP =
    256'h00000000_a97d9f93_1f800180_00000000_ed709c71_06060c00_00000000_00e29290;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_valid, cmd_ready;
  logic [IDX_W-1:0] cmd_first, cmd_end;
  logic             grp_valid, grp_ready;
  logic [255:0]     grp_src1, grp_src2;
  logic             res_valid;
  logic [255:0]     res_data;
  logic [IDX_W-1:0] res_index, pos_idx;
  logic             done;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  sm3me_unit #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_first(cmd_first), .cmd_end(cmd_end),
    .grp_valid(grp_valid), .grp_ready(grp_ready),
    .grp_src1(grp_src1), .grp_src2(grp_src2),
    .res_valid(res_valid), .res_data(res_data), .res_index(res_index),
    .pos_idx(pos_idx), .done(done)
  );

  function automatic logic [31:0] m_swap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction
  function automatic logic [31:0] m_rol(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction
  function automatic logic [255:0] model(input logic [255:0] a, input logic [255:0] b);
    logic [31:0] w [24];
    logic [255:0] r;
    for (int k = 0; k < 8; k++) begin
      w[k]   = m_swap(a[k*32 +: 32]);
      w[k+8] = m_swap(b[k*32 +: 32]);
    end
    for (int j = 0; j < 8; j++) begin
      logic [31:0] t;
      t = w[j] ^ w[j+7] ^ m_rol(w[j+13], 15);
      w[j+16] = t ^ m_rol(t, 15) ^ m_rol(t, 23) ^ m_rol(w[j+3], 7) ^ w[j+10];
    end
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = m_swap(w[k+16]);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue_cmd(input int first, input int last);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_first = IDX_W'(first);
    cmd_end   = IDX_W'(last);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_first = '0; cmd_end = '0;
    grp_valid = 1'b0; grp_src1 = '0; grp_src2 = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 cmd_ready", 256'(cmd_ready), 256'd1);
    chk("R10 grp_ready", 256'(grp_ready), 256'd0);
    chk("R10 res_valid", 256'(res_valid), 256'd0);
    chk("R10 done", 256'(done), 256'd0);
    chk("R10 pos_idx", 256'(pos_idx), 256'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: one-group runs, R1 R2 R3 R4 R5 R7
    for (int v = 0; v < NVEC; v++) begin
      issue_cmd(0, 1);
      chk("R6 grp_ready after cmd", 256'(grp_ready), 256'd1);
      grp_valid = 1'b1;
      grp_src1  = TV_S1[v];
      grp_src2  = TV_S2[v];
      @(negedge clk);
      grp_valid = 1'b0;
      chk("R5 res_valid", 256'(res_valid), 256'd1);
      chk((v == 4) ? "R3 chained data" : "R1 R2 R4 data", res_data,
          model(TV_S1[v], TV_S2[v]));
      if (v == 0) chk("R2 abc constants", res_data, ABC_EXP);
      chk("R7 done with last", 256'(done), 256'd1);
      chk("R7 pos_idx cleared", 256'(pos_idx), 256'd0);
      @(negedge clk);
      chk("R7 done one cycle", 256'(done), 256'd0);
      chk("R5 res_valid drops", 256'(res_valid), 256'd0);
    end

    // multi-group run 2..4 with a competing command held high (R6 R9)
    issue_cmd(2, 5);
    chk("R6 pos_idx start", 256'(pos_idx), 256'd2);
    chk("R9 cmd_ready busy", 256'(cmd_ready), 256'd0);
    cmd_valid = 1'b1; cmd_first = 8'd7; cmd_end = 8'd9;
    for (int g = 0; g < 3; g++) begin
      grp_valid = 1'b1;
      grp_src1  = TV_S1[3] ^ {8{32'(g)}};
      grp_src2  = TV_S2[3];
      @(negedge clk);
      chk("R6 res_index", 256'(res_index), 256'(g + 2));
      chk("R5 R6 data", res_data, model(TV_S1[3] ^ {8{32'(g)}}, TV_S2[3]));
      chk("R7 R9 done timing", 256'(done), 256'(g == 2));
    end
    grp_valid = 1'b0;
    cmd_valid = 1'b0;
    chk("R7 idle pos_idx", 256'(pos_idx), 256'd0);
    @(negedge clk);
    chk("R9 no extra run", 256'(grp_ready), 256'd0);
    chk("R7 done low", 256'(done), 256'd0);

    // empty range (R8)
    issue_cmd(3, 3);
    chk("R8 done", 256'(done), 256'd1);
    chk("R8 no result", 256'(res_valid), 256'd0);
    chk("R8 stays idle", 256'(cmd_ready), 256'd1);
    @(negedge clk);
    chk("R8 done one cycle", 256'(done), 256'd0);

    // group offered while idle is ignored (R6)
    grp_valid = 1'b1;
    grp_src1  = TV_S1[0];
    @(negedge clk);
    grp_valid = 1'b0;
    chk("R6 idle group ignored", 256'(res_valid), 256'd0);
    chk("R6 idle pos_idx", 256'(pos_idx), 256'd0);

    // reset during a run (R10)
    issue_cmd(1, 4);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid-run reset grp_ready", 256'(grp_ready), 256'd0);
    chk("R10 mid-run reset pos_idx", 256'(pos_idx), 256'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule